// File: doc/BRIEF.md
# Five-Step Margin Compare Sequencer

This block runs a batch of margin compare operations against a nonvolatile memory array. Each compare step drives three 2-bit read-margin settings to the array: a current-level trim, a timing trim and a bias trim. The sequencer holds these settings steady for a settle window and then raises a compare strobe. It waits for the array's recall-ready indication and samples the array's match flag. There are five steps, and the settings for each step are unpacked from a continuous stream of 2-bit fields. That stream is spread across four byte-wide configuration registers.

Software loads the configuration bytes and then writes a command code. Command codes are: 0 = return to idle mode, 1 = enter keep mode, 2 = single compare (step 0 only), 3 = full five-step run. While a command is in progress the ready output is low. When a run ends, ready returns high and the pass output gives the aggregate result. If the array never answers a compare, a programmable watchdog aborts the run. The settings currently driven to the array double as status, so every step can be observed as its own compare pulse.

Top module: `margin_scan_seq`

## Requirements
- R1: After reset, stReady is 1 and stPass, stKeep, stTimedOut and arrComp are 0.
- R2: The four configuration bytes form one 32-bit stream {reg3,reg2,reg1,reg0}, selected by cfgAddr 0..3. For step n, the timing trim is stream bits [6n+1:6n], the current trim is bits [6n+3:6n+2] and the bias trim is bits [6n+5:6n+4]. Bits [7:6] of reg3 are unused.
- R3: A full run (code 3) produces exactly five arrComp pulses, for steps 0 to 4 in order. During each pulse, arrTecc, arrMrcl and arrBias carry that step's fields and do not change.
- R4: Before arrComp rises, the three settings have been stable for at least SETTLE_CYCLES cycles.
- R5: arrComp stays high until arrRcReady is seen, and the match flag is sampled on that cycle. arrComp is then low for at least one cycle before the next step.
- R6: At the end of a run, stPass is 1 only if every step matched. A mismatch does not stop the later steps from running.
- R7: A valid command (codes 0 to 3) accepted while stReady is high drops stReady on the next cycle. stReady stays low until the command completes.
- R8: Code 1 sets stKeep and code 0 clears it. Each of these holds stReady low for exactly one cycle.
- R9: Code 2 runs a single compare pulse with the step 0 fields. stPass then equals that step's match.
- R10: If arrRcReady has not arrived, arrComp drops after timeoutLimit+1 cycles high. The run ends with stPass 0 and stTimedOut 1, and stTimedOut is cleared when the next compare run starts.
- R11: Commands presented while stReady is low are ignored, and so are codes 4 to 7. Neither changes stKeep or starts a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration byte write enable |
| cfgAddr | input | 2 | Configuration byte select |
| cfgWdata | input | 8 | Configuration byte data |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code |
| timeoutLimit | input | 16 | Watchdog limit in cycles |
| arrRcReady | input | 1 | Array recall-ready |
| arrMatch | input | 1 | Array compare match |
| arrTecc | output | 2 | Timing trim driven to array |
| arrMrcl | output | 2 | Current trim driven to array |
| arrBias | output | 2 | Bias trim driven to array |
| arrComp | output | 1 | Compare strobe |
| stReady | output | 1 | Idle and able to take a command |
| stPass | output | 1 | Result of last compare run |
| stKeep | output | 1 | Keep mode status |
| stTimedOut | output | 1 | Last run ended by watchdog |

## Verification
A wrong step index or a bad field unpack shows up at the array pins within the same compare pulse: the triple there differs from the one computed from the stream. A stuck accumulator shows on stPass at the cycle ready returns. A miscounted settle or watchdog counter changes the distance from a settings change to the compare edge, or changes the length of a compare pulse. Both are measured in whole cycles at the pins. A sequencer that stops early or loops gives the wrong number of compare pulses before ready comes back.

// File: rtl/margin_scan_pkg.sv
`timescale 1ns/1ps
package margin_scan_pkg;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_IDLE    = 3'd0;
  localparam logic [CMD_W-1:0] CMD_KEEP    = 3'd1;
  localparam logic [CMD_W-1:0] CMD_COMPARE = 3'd2;
  localparam logic [CMD_W-1:0] CMD_AUTO    = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE,
    ST_SETTLE,
    ST_COMP,
    ST_GAP
  } seqState_t;

  typedef struct packed {
    logic startRun;
    logic runSingle;
    logic cntClr;
    logic sampleMatch;
    logic stepAdv;
    logic finishRun;
    logic abortRun;
    logic setKeep;
    logic clrKeep;
  } seqStrobe_t;

endpackage

// File: rtl/margin_scan_dp.sv
`timescale 1ns/1ps
module margin_scan_dp
  import margin_scan_pkg::*;
#(
  parameter int NUM_STEPS     = 5,
  parameter int FIELD_W       = 2,
  parameter int SETTLE_CYCLES = 4,
  parameter int TMO_W         = 16,
  parameter int ADDR_W        = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [7:0]         cfgWdata,
  input  logic [TMO_W-1:0]   timeoutLimit,
  input  logic               arrMatch,
  input  seqStrobe_t         strobe,
  output logic               settleDone,
  output logic               waitExpired,
  output logic               lastStep,
  output logic [FIELD_W-1:0] teccOut,
  output logic [FIELD_W-1:0] mrclOut,
  output logic [FIELD_W-1:0] biasOut,
  output logic               passOut,
  output logic               keepOut,
  output logic               timedOutOut
);

  localparam int STEP_BITS = 3 * FIELD_W;
  localparam int STREAM_W  = NUM_STEPS * STEP_BITS;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(NUM_STEPS - 1);
  localparam logic [TMO_W-1:0]  SETTLE_END = TMO_W'(SETTLE_CYCLES - 1);

  // Packed configuration stream: only bits that feed a field are stored.
  logic [STREAM_W-1:0] cfgBits;

  for (genvar b = 0; b < STREAM_W; b++) begin : gCfgBit
    localparam int REG_SEL = b / 8;
    localparam int BIT_SEL = b % 8;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgBits[b] <= 1'b0;
      end else if (cfgWe && (int'(cfgAddr) == REG_SEL)) begin
        cfgBits[b] <= cfgWdata[BIT_SEL];
      end
    end
  end

  // Per-step field extraction: timing trim, then current trim, then bias.
  logic [FIELD_W-1:0] stepTecc [NUM_STEPS];
  logic [FIELD_W-1:0] stepMrcl [NUM_STEPS];
  logic [FIELD_W-1:0] stepBias [NUM_STEPS];

  for (genvar g = 0; g < NUM_STEPS; g++) begin : gStepField
    assign stepTecc[g] = cfgBits[g*STEP_BITS             +: FIELD_W];
    assign stepMrcl[g] = cfgBits[g*STEP_BITS + FIELD_W   +: FIELD_W];
    assign stepBias[g] = cfgBits[g*STEP_BITS + 2*FIELD_W +: FIELD_W];
  end

  // Step pointer and last-step bound.
  logic [STEP_W-1:0] stepIdx;
  logic [STEP_W-1:0] lastIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
      lastIdx <= LAST_IDX;
    end else if (strobe.startRun) begin
      stepIdx <= '0;
      lastIdx <= strobe.runSingle ? '0 : LAST_IDX;
    end else if (strobe.stepAdv) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  assign lastStep = (stepIdx == lastIdx);
  assign teccOut  = stepTecc[stepIdx];
  assign mrclOut  = stepMrcl[stepIdx];
  assign biasOut  = stepBias[stepIdx];

  // Shared delay counter: settle window and watchdog.
  logic [TMO_W-1:0] delayCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) begin
      delayCnt <= '0;
    end else if (delayCnt != '1) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  assign settleDone  = (delayCnt >= SETTLE_END);
  assign waitExpired = (delayCnt >= timeoutLimit);

  // Result accumulation and mode status.
  logic matchAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchAcc    <= 1'b1;
      passOut     <= 1'b0;
      timedOutOut <= 1'b0;
      keepOut     <= 1'b0;
    end else begin
      if (strobe.startRun) begin
        matchAcc    <= 1'b1;
        passOut     <= 1'b0;
        timedOutOut <= 1'b0;
      end else if (strobe.sampleMatch) begin
        matchAcc <= matchAcc & arrMatch;
      end
      if (strobe.finishRun) begin
        passOut <= matchAcc;
      end
      if (strobe.abortRun) begin
        passOut     <= 1'b0;
        timedOutOut <= 1'b1;
      end
      if (strobe.setKeep) begin
        keepOut <= 1'b1;
      end else if (strobe.clrKeep) begin
        keepOut <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/margin_scan_ctrl.sv
`timescale 1ns/1ps
module margin_scan_ctrl
  import margin_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             settleDone,
  input  logic             waitExpired,
  input  logic             lastStep,
  input  logic             arrRcReady,
  output seqStrobe_t       strobe,
  output logic             compOut,
  output logic             readyOut
);

  seqState_t state;
  seqState_t stateNext;
  logic      pendKeep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendKeep <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && cmdValid) begin
        pendKeep <= (cmdCode == CMD_KEEP);
      end
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          case (cmdCode)
            CMD_IDLE, CMD_KEEP: stateNext = ST_MODE;
            CMD_COMPARE, CMD_AUTO: begin
              strobe.startRun  = 1'b1;
              strobe.runSingle = (cmdCode == CMD_COMPARE);
              strobe.cntClr    = 1'b1;
              stateNext        = ST_SETTLE;
            end
            default: stateNext = ST_IDLE;
          endcase
        end
      end
      ST_MODE: begin
        strobe.setKeep = pendKeep;
        strobe.clrKeep = !pendKeep;
        stateNext      = ST_IDLE;
      end
      ST_SETTLE: begin
        if (settleDone) begin
          strobe.cntClr = 1'b1;
          stateNext     = ST_COMP;
        end
      end
      ST_COMP: begin
        if (arrRcReady) begin
          strobe.sampleMatch = 1'b1;
          stateNext          = ST_GAP;
        end else if (waitExpired) begin
          strobe.abortRun = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (lastStep) begin
          strobe.finishRun = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          strobe.stepAdv = 1'b1;
          strobe.cntClr  = 1'b1;
          stateNext      = ST_SETTLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign compOut  = (state == ST_COMP);
  assign readyOut = (state == ST_IDLE);

endmodule

// File: rtl/margin_scan_seq.sv
`timescale 1ns/1ps
module margin_scan_seq
  import margin_scan_pkg::*;
#(
  parameter int NUM_STEPS     = 5,
  parameter int FIELD_W       = 2,
  parameter int SETTLE_CYCLES = 4,
  parameter int TMO_W         = 16
) (
  input  logic                                            clk,
  input  logic                                            rstN,
  input  logic                                            cfgWe,
  input  logic [$clog2((NUM_STEPS*3*FIELD_W+7)/8)-1:0]     cfgAddr,
  input  logic [7:0]                                      cfgWdata,
  input  logic                                            cmdValid,
  input  logic [2:0]                                      cmdCode,
  input  logic [TMO_W-1:0]                                timeoutLimit,
  input  logic                                            arrRcReady,
  input  logic                                            arrMatch,
  output logic [FIELD_W-1:0]                              arrTecc,
  output logic [FIELD_W-1:0]                              arrMrcl,
  output logic [FIELD_W-1:0]                              arrBias,
  output logic                                            arrComp,
  output logic                                            stReady,
  output logic                                            stPass,
  output logic                                            stKeep,
  output logic                                            stTimedOut
);

  localparam int ADDR_W = $clog2((NUM_STEPS*3*FIELD_W+7)/8);

  seqStrobe_t strobe;
  logic       settleDone;
  logic       waitExpired;
  logic       lastStep;

  margin_scan_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdCode     (cmdCode),
    .settleDone  (settleDone),
    .waitExpired (waitExpired),
    .lastStep    (lastStep),
    .arrRcReady  (arrRcReady),
    .strobe      (strobe),
    .compOut     (arrComp),
    .readyOut    (stReady)
  );

  margin_scan_dp #(
    .NUM_STEPS     (NUM_STEPS),
    .FIELD_W       (FIELD_W),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .TMO_W         (TMO_W),
    .ADDR_W        (ADDR_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWe        (cfgWe),
    .cfgAddr      (cfgAddr),
    .cfgWdata     (cfgWdata),
    .timeoutLimit (timeoutLimit),
    .arrMatch     (arrMatch),
    .strobe       (strobe),
    .settleDone   (settleDone),
    .waitExpired  (waitExpired),
    .lastStep     (lastStep),
    .teccOut      (arrTecc),
    .mrclOut      (arrMrcl),
    .biasOut      (arrBias),
    .passOut      (stPass),
    .keepOut      (stKeep),
    .timedOutOut  (stTimedOut)
  );

endmodule

// File: rtl/margin_scan_chk.sv
`timescale 1ns/1ps
module margin_scan_chk #(
  parameter int FIELD_W       = 2,
  parameter int SETTLE_CYCLES = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic [2:0]         cmdCode,
  input logic               arrRcReady,
  input logic               arrComp,
  input logic [FIELD_W-1:0] arrTecc,
  input logic [FIELD_W-1:0] arrMrcl,
  input logic [FIELD_W-1:0] arrBias,
  input logic               stReady,
  input logic               stPass,
  input logic               stKeep,
  input logic               stTimedOut
);

  // Counts edges for which the settings have held their value.
  logic [3*FIELD_W-1:0] prevTrip;
  logic [15:0]          stableCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTrip  <= {arrTecc, arrMrcl, arrBias};
      stableCnt <= '0;
    end else begin
      prevTrip <= {arrTecc, arrMrcl, arrBias};
      if ({arrTecc, arrMrcl, arrBias} != prevTrip) begin
        stableCnt <= '0;
      end else if (stableCnt != 16'hFFFF) begin
        stableCnt <= stableCnt + 16'd1;
      end
    end
  end

  assert_settle_before_comp_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arrComp) |-> (int'(stableCnt) >= SETTLE_CYCLES - 1));

  assert_params_hold_in_comp_R3: assert property (@(posedge clk) disable iff (!rstN)
    (arrComp && $past(arrComp)) |-> $stable({arrTecc, arrMrcl, arrBias}));

  assert_comp_ends_on_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(arrComp) |-> ($past(arrRcReady) || stTimedOut));

  assert_comp_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(arrComp) |=> !arrComp);

  assert_busy_on_command_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stReady && cmdValid && cmdCode <= 3'd3) |=> !stReady);

  assert_comp_means_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    arrComp |-> !stReady);

  assert_pass_at_finish_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stPass) |-> $rose(stReady));

  assert_unknown_code_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stReady && cmdValid && cmdCode > 3'd3) |=> (stReady && $stable(stKeep)));

  assert_keep_changes_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stKeep) |-> ($rose(stReady)));

endmodule

bind margin_scan_seq margin_scan_chk #(
  .FIELD_W       (FIELD_W),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) uChk (.*);

// File: tb/sim_margin_scan_seq.sv
`timescale 1ns/1ps
module sim_margin_scan_seq;

  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgWdata = '0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = '0;
  logic [15:0] timeoutLimit = 16'd200;
  logic       arrRcReady = 1'b0;
  logic       arrMatch = 1'b1;
  logic [1:0] arrTecc, arrMrcl, arrBias;
  logic       arrComp, stReady, stPass, stKeep, stTimedOut;

  int nChecks = 0;
  int nFails  = 0;

  // Stub controls (written by the test sequence only)
  logic       stubEn = 1'b1;
  int         stubLat = 3;
  logic       badEn = 1'b0;
  logic [5:0] badTrip = '0;
  logic [7:0] cfgB [4];

  // Monitor-owned state
  logic [5:0] logTrip [64];
  int pulseCnt = 0;
  int settleBad = 0;
  int lenBad = 0;
  int lastLen = 0;
  int curLen = 0;
  int sc = 0;
  int stubCnt = 0;
  logic [5:0] prevTrip = '0;
  logic prevComp = 1'b0;

  margin_scan_seq u0 (.*);

  always #2.5 clk = ~clk;

  // Array stub and pin monitor, evaluated away from the active edge
  always @(negedge clk) begin
    logic [5:0] trip;
    trip = {arrTecc, arrMrcl, arrBias};
    if (trip != prevTrip) sc = 0;
    else if (sc < 100000) sc = sc + 1;
    prevTrip = trip;
    if (arrComp && !prevComp) begin
      logTrip[pulseCnt % 64] = trip;
      if (sc < SETTLE) settleBad = settleBad + 1;
      curLen = 0;
      pulseCnt = pulseCnt + 1;
    end
    if (arrComp) curLen = curLen + 1;
    if (!arrComp && prevComp) begin
      lastLen = curLen;
      if (stubEn && curLen != stubLat) lenBad = lenBad + 1;
    end
    prevComp = arrComp;
    if (arrComp) stubCnt = stubCnt + 1;
    else stubCnt = 0;
    arrRcReady = arrComp && stubEn && (stubCnt >= stubLat);
    arrMatch = !(badEn && trip == badTrip);
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [5:0] expTrip(input int s);
    logic [1:0] f [3];
    for (int k = 0; k < 3; k++) begin
      int idx = (3 * s + k) * 2;
      f[k] = 2'((cfgB[idx / 8] >> (idx % 8)) & 8'h03);
    end
    return {f[0], f[1], f[2]};
  endfunction

  task automatic writeCfg(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] b3);
    cfgB[0] = b0; cfgB[1] = b1; cfgB[2] = b2; cfgB[3] = b3;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      cfgWe = 1'b1; cfgAddr = 2'(r); cfgWdata = cfgB[r];
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseCmd(input logic [2:0] code);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitReady(input int maxCycles);
    for (int i = 0; i < maxCycles && !stReady; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check(stReady == 1'b1, "R1 ready", stReady, 1);
    check(stPass == 1'b0 && stKeep == 1'b0 && stTimedOut == 1'b0 && arrComp == 1'b0,
          "R1 status", {stPass, stKeep, stTimedOut, arrComp}, 0);
  endtask

  task automatic t_run(input logic [2:0] code, input int nSteps, input string tag);
    int base, sb, lb;
    bit expPass;
    base = pulseCnt; sb = settleBad; lb = lenBad;
    pulseCmd(code);
    check(stReady == 1'b0, {"R7 busy ", tag}, stReady, 0);
    waitReady(2000);
    @(negedge clk);
    check(pulseCnt - base == nSteps, {"R3/R6 pulse count ", tag}, pulseCnt - base, nSteps);
    expPass = 1'b1;
    for (int s = 0; s < nSteps; s++) begin
      logic [5:0] e = expTrip(s);
      check(logTrip[(base + s) % 64] == e, {"R2/R3 step fields ", tag},
            logTrip[(base + s) % 64], e);
      if (badEn && e == badTrip) expPass = 1'b0;
    end
    check(settleBad == sb, {"R4 settle ", tag}, settleBad - sb, 0);
    check(lenBad == lb, {"R5 comp length ", tag}, lenBad - lb, 0);
    check(stPass == expPass, {"R6/R9 pass ", tag}, stPass, expPass);
    check(stTimedOut == 1'b0, {"R10 no timeout ", tag}, stTimedOut, 0);
  endtask

  task automatic t_keep_idle;
    pulseCmd(3'd1);
    check(stReady == 1'b0, "R8 keep busy", stReady, 0);
    @(negedge clk);
    check(stReady == 1'b1 && stKeep == 1'b1, "R8 keep set", {stReady, stKeep}, 3);
    pulseCmd(3'd0);
    check(stReady == 1'b0, "R8 idle busy", stReady, 0);
    @(negedge clk);
    check(stReady == 1'b1 && stKeep == 1'b0, "R8 keep clear", {stReady, stKeep}, 2);
  endtask

  task automatic t_ignore;
    int base;
    pulseCmd(3'd6);
    check(stReady == 1'b1, "R11 unknown code", stReady, 1);
    @(negedge clk);
    check(stKeep == 1'b0 && arrComp == 1'b0, "R11 unknown no effect", {stKeep, arrComp}, 0);
    stubLat = 10;
    base = pulseCnt;
    pulseCmd(3'd3);
    repeat (3) @(negedge clk);
    pulseCmd(3'd1);
    pulseCmd(3'd2);
    waitReady(2000);
    @(negedge clk);
    check(stKeep == 1'b0, "R11 busy keep ignored", stKeep, 0);
    check(pulseCnt - base == 5, "R11 busy compare ignored", pulseCnt - base, 5);
    stubLat = 3;
  endtask

  task automatic t_timeout;
    int base;
    stubEn = 1'b0;
    timeoutLimit = 16'd40;
    base = pulseCnt;
    pulseCmd(3'd3);
    waitReady(2000);
    @(negedge clk);
    check(stTimedOut == 1'b1 && stPass == 1'b0, "R10 abort flags", {stTimedOut, stPass}, 2);
    check(pulseCnt - base == 1, "R10 single pulse", pulseCnt - base, 1);
    check(lastLen == 41, "R10 comp length", lastLen, 41);
    stubEn = 1'b1;
    timeoutLimit = 16'd200;
    pulseCmd(3'd2);
    check(stTimedOut == 1'b0, "R10 flag cleared on start", stTimedOut, 0);
    waitReady(2000);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    writeCfg(8'h1B, 8'hE4, 8'h93, 8'h2D);
    t_run(3'd3, 5, "all match");
    writeCfg(8'hC6, 8'h5A, 8'h3F, 8'hF9);
    badEn = 1'b1; badTrip = expTrip(2);
    t_run(3'd3, 5, "mismatch mid");
    badTrip = expTrip(4);
    stubLat = 1;
    t_run(3'd3, 5, "mismatch last");
    stubLat = 3;
    badTrip = expTrip(0);
    t_run(3'd2, 1, "single fail");
    badEn = 1'b0;
    t_run(3'd2, 1, "single pass");
    t_keep_idle();
    t_ignore();
    t_timeout();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL R7 watchdog: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule